// File: doc/BRIEF.md
# ADC Input Scan Sequencer

This block picks the analog input index that the primary sample channel converts next. In scan mode it steps through the inputs whose bit is set in a 32-bit enable mask, in ascending order, and passes over every input whose bit is clear. The mask arrives as two 16-bit halves: the low half covers inputs 0 to 15 and the high half covers inputs 16 to 31. After the highest enabled input it returns to the lowest one and raises a one-clock wrap pulse.

When scanning is off, the index comes from one of two fixed selections, A and B. In alternate mode the index switches between A and B on each conversion, and it always starts from A. With alternate mode also off, the index follows selection A. The surrounding converter pulses `advance` once per conversion.

The index is registered, so a change at the inputs appears at `cur_idx` one clock later.

Top module: `adc_scan_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, `cur_idx` is 0 and `wrap` is 0.
- R2: In scan mode, each `advance` moves `cur_idx` to the smallest enabled input above its current value, one clock later. The enable bit for input i is bit i of the concatenation {mask_hi, mask_lo}.
- R3: In scan mode, an `advance` taken from the highest enabled input loads the lowest enabled input and drives `wrap` high for exactly one clock. `wrap` is never high without an `advance` in scan mode in the previous cycle.
- R4: In scan mode, with a non-zero mask and no `advance`, no `mask_wr` and no rising edge of `scan_en`, `cur_idx` holds its value.
- R5: In scan mode with an all-zero mask, `cur_idx` equals selection A from the previous cycle and `wrap` stays 0.
- R6: A `mask_wr` pulse, or a rising edge of `scan_en`, restarts scanning at the lowest enabled input of the mask present in that cycle, with `wrap` 0.
- R7: With scan and alternate modes both off, `cur_idx` follows selection A one clock later, `advance` has no effect, and `wrap` is 0.
- R8: With scanning off and alternate mode on, the first index after alternate mode is enabled is selection A. An `advance` in the enabling cycle is ignored. Each later `advance` swaps to the other selection, and without `advance` the current selection is kept.
- R9: When `scan_en` and `alt_en` are both high, scanning takes priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_lo | input | 16 | Scan enables for inputs 0..15 |
| mask_hi | input | 16 | Scan enables for inputs 16..31 |
| mask_wr | input | 1 | Pulse marking a mask write; restarts the scan |
| scan_en | input | 1 | Scan mode enable |
| alt_en | input | 1 | Alternate A/B mode enable (used when not scanning) |
| advance | input | 1 | One pulse per conversion |
| sel_a | input | 5 | Fixed input selection A |
| sel_b | input | 5 | Fixed input selection B |
| cur_idx | output | 5 | Input index for the primary sample channel |
| wrap | output | 1 | One-clock pulse when the scan returns to its lowest input |

## Verification
The bench builds the block with the default half width of 16, which gives the full 32-input mask. This lets the sweep walk every single-bit mask, the empty mask, the full mask and a set of pseudo-random sparse masks. Each walk runs for more advances than there are inputs, so every mask wraps at least once, including masks whose only bits lie in the high half. Short directed sequences then cover restart on a rising scan enable, the A/B alternation and its start-up rule, and the priority of scan over alternate mode.

// File: rtl/adc_scan_sequencer.sv
module adc_scan_sequencer #(
  parameter int HALF_W = 16,
  localparam int NUM_IN = 2 * HALF_W,
  localparam int IDX_W = $clog2(NUM_IN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HALF_W-1:0] mask_lo,
  input  logic [HALF_W-1:0] mask_hi,
  input  logic             mask_wr,
  input  logic             scan_en,
  input  logic             alt_en,
  input  logic             advance,
  input  logic [IDX_W-1:0] sel_a,
  input  logic [IDX_W-1:0] sel_b,
  output logic [IDX_W-1:0] cur_idx,
  output logic             wrap
);

  logic [NUM_IN-1:0] mask;
  logic [IDX_W-1:0]  low_idx, above_idx, nxt_idx;
  logic              has_above, any_en, nxt_wrap;
  logic              scan_q, alt_q, use_b, use_b_n;
  logic              restart, alt_act;

  assign mask    = {mask_hi, mask_lo};
  assign any_en  = |mask;
  assign restart = scan_en & (mask_wr | ~scan_q);
  assign alt_act = alt_en & ~scan_en;
  assign use_b_n = (alt_act & alt_q) ? (use_b ^ advance) : 1'b0;

  always_comb begin
    low_idx   = '0;
    above_idx = '0;
    has_above = 1'b0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (mask[i]) low_idx = IDX_W'(i);
      if (mask[i] && i > int'(cur_idx)) begin
        above_idx = IDX_W'(i);
        has_above = 1'b1;
      end
    end
  end

  always_comb begin
    nxt_idx  = cur_idx;
    nxt_wrap = 1'b0;
    if (scan_en) begin
      if (!any_en) nxt_idx = sel_a;
      else if (restart) nxt_idx = low_idx;
      else if (advance) begin
        if (has_above) nxt_idx = above_idx;
        else begin
          nxt_idx  = low_idx;
          nxt_wrap = 1'b1;
        end
      end
    end else if (alt_act) begin
      nxt_idx = use_b_n ? sel_b : sel_a;
    end else begin
      nxt_idx = sel_a;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_idx <= '0;
      wrap    <= 1'b0;
      scan_q  <= 1'b0;
      alt_q   <= 1'b0;
      use_b   <= 1'b0;
    end else begin
      cur_idx <= nxt_idx;
      wrap    <= nxt_wrap;
      scan_q  <= scan_en;
      alt_q   <= alt_act;
      use_b   <= use_b_n;
    end
  end

  assert_wrap_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> ($past(advance) && $past(scan_en)));

  assert_scan_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && scan_q && !mask_wr && !advance && any_en) |=> $stable(cur_idx));

  assert_empty_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !any_en) |=> (cur_idx == $past(sel_a) && !wrap));

  assert_restart_nowrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !wrap);

  assert_plain_follows_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !alt_en) |=> (cur_idx == $past(sel_a) && !wrap));

endmodule

// File: tb/adc_scan_sequencer_test.sv
`timescale 1ns/1ps
module adc_scan_sequencer_test;
  logic        clk = 0, rst_n = 0;
  logic [15:0] mask_lo = '0, mask_hi = '0;
  logic        mask_wr = 0, scan_en = 0, alt_en = 0, advance = 0;
  logic [4:0]  sel_a = '0, sel_b = '0;
  logic [4:0]  cur_idx;
  logic        wrap;
  int checks = 0, fails = 0;
  bit done = 0;

  adc_scan_sequencer uut (.clk(clk), .rst_n(rst_n), .mask_lo(mask_lo), .mask_hi(mask_hi),
    .mask_wr(mask_wr), .scan_en(scan_en), .alt_en(alt_en), .advance(advance),
    .sel_a(sel_a), .sel_b(sel_b), .cur_idx(cur_idx), .wrap(wrap));

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int lowest(input logic [31:0] m);
    for (int i = 0; i < 32; i++) if (m[i]) return i;
    return -1;
  endfunction

  function automatic int above(input logic [31:0] m, input int c);
    for (int i = c + 1; i < 32; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_2468;
    @(negedge clk);
    chk("R1 idx in reset", cur_idx, 0);
    chk("R1 wrap in reset", wrap, 0);
    tick();
    rst_n = 1;
    @(negedge clk);
    chk("R1 idx after reset", cur_idx, 0);
    chk("R1 wrap after reset", wrap, 0);

    for (int k = 0; k < 56; k++) begin
      logic [31:0] m;
      int exp_i, exp_w, nx;
      if (k < 32) m = 32'd1 << k;
      else if (k == 32) m = '0;
      else if (k == 33) m = '1;
      else begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        m = lfsr & (lfsr >> 5) & ((k[0]) ? 32'hFFFF_0000 : 32'hFFFF_FFFF);
      end
      sel_a = 5'(k);
      {mask_hi, mask_lo} = m;
      scan_en = 1; alt_en = 0; mask_wr = 1; advance = 0;
      tick();
      mask_wr = 0;
      exp_i = (m == 0) ? k % 32 : lowest(m);
      chk(m == 0 ? "R5 empty mask restart" : "R6 restart on mask write", cur_idx, exp_i);
      chk("R6 no wrap on restart", wrap, 0);
      for (int s = 0; s < 34; s++) begin
        advance = 1;
        tick();
        if (m == 0) begin exp_i = k % 32; exp_w = 0; end
        else begin
          nx = above(m, exp_i);
          if (nx >= 0) begin exp_i = nx; exp_w = 0; end
          else begin exp_i = lowest(m); exp_w = 1; end
        end
        chk(m == 0 ? "R5 empty mask idx" : "R2 scan step", cur_idx, exp_i);
        chk(exp_w ? "R3 wrap pulse" : "R3 no wrap", wrap, exp_w);
      end
      advance = 0;
      tick();
      chk("R4 hold without advance", cur_idx, exp_i);
      chk("R3 wrap one clock only", wrap, 0);
    end

    // restart on rising scan_en
    {mask_hi, mask_lo} = 32'h00F0_0000; sel_a = 5'd2; mask_wr = 1; tick(); mask_wr = 0;
    advance = 1; tick(); advance = 0;
    chk("R2 step into high half", cur_idx, 21);
    scan_en = 0; tick();
    chk("R7 scan off gives A", cur_idx, 2);
    scan_en = 1; tick();
    chk("R6 restart on scan rise", cur_idx, 20);

    // plain mode
    scan_en = 0; alt_en = 0; sel_a = 5'd3; sel_b = 5'd9; advance = 1; tick();
    chk("R7 plain A with advance", cur_idx, 3);
    chk("R7 plain no wrap", wrap, 0);
    sel_a = 5'd4; tick();
    chk("R7 follows A", cur_idx, 4);

    // alternate mode
    alt_en = 1; advance = 1; tick();
    chk("R8 starts with A", cur_idx, 4);
    tick(); chk("R8 swap to B", cur_idx, 9);
    tick(); chk("R8 swap to A", cur_idx, 4);
    tick(); chk("R8 swap to B again", cur_idx, 9);
    advance = 0; tick(); chk("R8 hold B", cur_idx, 9);
    advance = 1; tick(); chk("R8 back to A", cur_idx, 4);
    tick(); chk("R8 to B before disable", cur_idx, 9);
    alt_en = 0; advance = 0; tick(); chk("R7 alt off gives A", cur_idx, 4);
    alt_en = 1; tick(); chk("R8 re-enable starts A", cur_idx, 4);
    advance = 1; tick(); chk("R8 first swap after re-enable", cur_idx, 9);

    // priority
    advance = 0; {mask_hi, mask_lo} = 32'h0000_0030; scan_en = 1; tick();
    chk("R9 scan wins restart", cur_idx, 4);
    advance = 1; tick();
    chk("R9 scan wins step", cur_idx, 5);
    tick();
    chk("R9 scan wins wrap idx", cur_idx, 4);
    chk("R9 scan wins wrap flag", wrap, 1);
    advance = 0;
    tick();
    summary();
  end
endmodule